// File: doc/BRIEF.md
# PWM Output Overlevel Persistence Guard

This block protects a differential PWM output stage. It takes a sampled level code for the output and a code for the supply reference. It decides whether the output has stayed too high for too long. Two independent channels watch the same level. The "fixed" channel uses a hard-wired ratio of 124/128 of the supply. The "programmable" channel uses a ratio of `prog_lvl`/128. Each channel has its own enable and its own persistence limit. The limit is counted in strobes of a slow timebase of about 3 kHz, delivered on `tick`.

No divider is used. A channel sees an overlevel when `128 × level_code ≥ threshold × supply_code`, computed at full integer width. When a channel reaches its limit, the block latches a fault. The fault drives the force-low request for both the positive and the negative output leg, and it holds until `fault_clr` is pulsed or the block is reset. The register fields arrive as plain inputs. Their reset values belong to the register bank outside this block.

Top module: `pwm_overlevel_guard`

## Requirements
- R1: While reset is held, and right after it, `fault`, `leg_p_low` and `leg_n_low` are 0.
- R2: The fixed channel counts a tick as overlevel when 128·`level_code` ≥ 124·`supply_code`. Equality counts as overlevel.
- R3: The programmable channel counts a tick as overlevel when 128·`level_code` ≥ `prog_lvl`·`supply_code`. A `prog_lvl` of 0 makes every tick overlevel.
- R4: An enabled channel with a limit N ≥ 1 trips on the N-th consecutive overlevel tick. It does not trip after N−1 such ticks. The fixed limit is `fix_time` and the programmable limit is `prog_time`.
- R5: A limit of 0 trips on the first overlevel tick.
- R6: A tick that is not overlevel restarts that channel's count from zero.
- R7: While a channel's enable is low, its count is held at zero and it cannot trip.
- R8: A trip sets `fault`, and both leg outputs are driven to 1 on the next clock edge. All three stay at 1 until `fault_clr` or reset.
- R9: If a trip and `fault_clr` happen in the same cycle, the trip wins.
- R10: Cycles with `tick` low neither advance a count nor set the fault.
- R11: The count saturates and does not wrap. While the level stays high after a trip, each further tick trips again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| tick | input | 1 | One-cycle timebase strobe, about 3 kHz |
| level_code | input | LVL_W | Sampled output level code |
| supply_code | input | LVL_W | Supply reference code on the same scale |
| fix_en | input | 1 | Fixed-threshold channel enable |
| fix_time | input | FIX_TIME_W | Fixed channel persistence limit, in ticks |
| prog_en | input | 1 | Programmable-threshold channel enable |
| prog_lvl | input | THR_W | Programmable threshold numerator over 128 |
| prog_time | input | PRG_TIME_W | Programmable channel persistence limit, in ticks |
| fault_clr | input | 1 | One-cycle clear of the latched fault |
| leg_p_low | output | 1 | Force positive output leg low |
| leg_n_low | output | 1 | Force negative output leg low |
| fault | output | 1 | Sticky protection fault flag |

## Verification
A tick sampled at a clock edge updates the counts at that edge. If that tick completes a trip, `fault` and both leg outputs rise at the same edge, so they are one register away from the tick. A `fault_clr` also takes effect at the edge that samples it. The bench drives every input on the falling clock edge and holds a tick for exactly one cycle. It then reads the outputs on the next falling edge, which is half a cycle after the edge that must have produced the result. Before each vector, both enables are dropped and a clear is pulsed for one cycle. Every vector therefore starts with zero counts and no fault.

// File: rtl/ovg_pkg.sv
package ovg_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_FIX = 0;
  localparam int CH_PRG = 1;
  localparam int SCALE_SHIFT = 7;   // threshold ratios are over 128
endpackage

// File: rtl/ovg_rst_sync.sv
module ovg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ovg_level_cmp.sv
module ovg_level_cmp #(
  parameter int LVL_W = 10,
  parameter int THR_W = 7
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] supply_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             over_o
);
  import ovg_pkg::*;
  localparam int PROD_W = LVL_W + ((THR_W > SCALE_SHIFT) ? THR_W : SCALE_SHIFT) + 1;

  logic [PROD_W-1:0] lhs, rhs;

  always_comb begin
    lhs    = PROD_W'(level_i) << SCALE_SHIFT;
    rhs    = PROD_W'(thr_i) * PROD_W'(supply_i);
    over_o = (lhs >= rhs);
  end
endmodule

// File: rtl/ovg_persist_ctr.sv
module ovg_persist_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             over_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             trip_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic [CNT_W:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    trip_o  = en_i && tick_i && over_i && (cnt_inc >= {1'b0, limit_i});
    cnt_ce  = !en_i || tick_i;
    cnt_d   = cnt_q;
    if (!en_i)                cnt_d = '0;
    else if (!over_i)         cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0)); // R7
  AST_UNDER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && !over_i) |=> (cnt_q == '0)); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && over_i) |=> (cnt_q >= $past(cnt_q))); // R11
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/pwm_overlevel_guard.sv
module pwm_overlevel_guard #(
  parameter int LVL_W      = 10,
  parameter int THR_W      = 7,
  parameter int FIX_TIME_W = 7,
  parameter int PRG_TIME_W = 8,
  parameter int FIX_THR    = 124
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [LVL_W-1:0]      level_code,
  input  logic [LVL_W-1:0]      supply_code,
  input  logic                  fix_en,
  input  logic [FIX_TIME_W-1:0] fix_time,
  input  logic                  prog_en,
  input  logic [THR_W-1:0]      prog_lvl,
  input  logic [PRG_TIME_W-1:0] prog_time,
  input  logic                  fault_clr,
  output logic                  leg_p_low,
  output logic                  leg_n_low,
  output logic                  fault
);
  import ovg_pkg::*;
  localparam int CNT_W = (FIX_TIME_W > PRG_TIME_W) ? FIX_TIME_W : PRG_TIME_W;

  logic                   rst_n_s;
  logic [NUM_CH-1:0]      ch_en, ch_over, ch_trip;
  logic [THR_W-1:0]       ch_thr   [NUM_CH];
  logic [CNT_W-1:0]       ch_limit [NUM_CH];
  logic                   fault_q, fault_d, fault_ce;

  ovg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  always_comb begin
    ch_en[CH_FIX]    = fix_en;
    ch_en[CH_PRG]    = prog_en;
    ch_thr[CH_FIX]   = THR_W'(FIX_THR);
    ch_thr[CH_PRG]   = prog_lvl;
    ch_limit[CH_FIX] = CNT_W'(fix_time);
    ch_limit[CH_PRG] = CNT_W'(prog_time);
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ovg_level_cmp #(.LVL_W(LVL_W), .THR_W(THR_W)) u_cmp (
      .level_i (level_code),
      .supply_i(supply_code),
      .thr_i   (ch_thr[g]),
      .over_o  (ch_over[g])
    );
    ovg_persist_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .en_i   (ch_en[g]),
      .tick_i (tick),
      .over_i (ch_over[g]),
      .limit_i(ch_limit[g]),
      .trip_o (ch_trip[g])
    );
  end

  always_comb begin
    fault_ce = (|ch_trip) || fault_clr;
    fault_d  = |ch_trip;          // trip wins over clear
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)      fault_q <= 1'b0;
    else if (fault_ce) fault_q <= fault_d;
  end

  assign fault     = fault_q;
  assign leg_p_low = fault_q;
  assign leg_n_low = fault_q;

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fault_q && !fault_clr) |=> fault_q); // R8
  AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!fault_q && !tick) |=> !fault_q); // R10
  AST_TRIP_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|ch_trip) |=> fault_q); // R9
endmodule

// File: tb/sim_pwm_overlevel_guard.sv
module sim_pwm_overlevel_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [9:0] level_code = '0, supply_code = '0;
  logic       fix_en = 1'b0, prog_en = 1'b0, fault_clr = 1'b0;
  logic [6:0] fix_time = '0, prog_lvl = '0;
  logic [7:0] prog_time = '0;
  logic       leg_p_low, leg_n_low, fault;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pwm_overlevel_guard u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level_code(level_code),
    .supply_code(supply_code), .fix_en(fix_en), .fix_time(fix_time),
    .prog_en(prog_en), .prog_lvl(prog_lvl), .prog_time(prog_time),
    .fault_clr(fault_clr), .leg_p_low(leg_p_low), .leg_n_low(leg_n_low),
    .fault(fault)
  );

  typedef struct packed {
    logic       fen;  logic [6:0] ftime;
    logic       pen;  logic [6:0] plvl; logic [7:0] ptime;
    logic [9:0] lvl;  logic [9:0] sup;
    logic [8:0] nt;   logic       exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 7'd3, 1'b0, 7'd0,  8'd0, 10'd97,   10'd100, 9'd3,  1'b1}, // R2 R4
    '{1'b1, 7'd3, 1'b0, 7'd0,  8'd0, 10'd97,   10'd100, 9'd2,  1'b0}, // R4
    '{1'b1, 7'd1, 1'b0, 7'd0,  8'd0, 10'd96,   10'd100, 9'd10, 1'b0}, // R2
    '{1'b1, 7'd1, 1'b0, 7'd0,  8'd0, 10'd124,  10'd128, 9'd1,  1'b1}, // R2 equality
    '{1'b0, 7'd0, 1'b1, 7'd64, 8'd5, 10'd50,   10'd100, 9'd5,  1'b1}, // R3 R4
    '{1'b0, 7'd0, 1'b1, 7'd64, 8'd1, 10'd49,   10'd100, 9'd20, 1'b0}, // R3
    '{1'b0, 7'd0, 1'b1, 7'd64, 8'd0, 10'd50,   10'd100, 9'd1,  1'b1}, // R5
    '{1'b1, 7'd0, 1'b0, 7'd0,  8'd0, 10'd97,   10'd100, 9'd1,  1'b1}, // R5
    '{1'b0, 7'd0, 1'b0, 7'd0,  8'd0, 10'd1023, 10'd100, 9'd20, 1'b0}, // R7
    '{1'b0, 7'd0, 1'b1, 7'd0,  8'd2, 10'd0,    10'd100, 9'd2,  1'b1}  // R3 zero threshold
  };

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp || leg_p_low !== exp || leg_n_low !== exp) begin
      n_bad++;
      $display("FAIL %s: fault=%b legs=%b%b expected %b", req, got, leg_p_low, leg_n_low, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic scrub();
    @(negedge clk) begin fix_en = 1'b0; prog_en = 1'b0; fault_clr = 1'b1; end
    @(negedge clk) fault_clr = 1'b0;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", fault, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", fault, 1'b0);

    for (int v = 0; v < 10; v++) begin
      scrub();
      fix_en = VECS[v].fen;  fix_time = VECS[v].ftime;
      prog_en = VECS[v].pen; prog_lvl = VECS[v].plvl; prog_time = VECS[v].ptime;
      level_code = VECS[v].lvl; supply_code = VECS[v].sup;
      ticks(int'(VECS[v].nt));
      check($sformatf("R2/R3/R4/R5/R7 vector %0d", v), fault, VECS[v].exp);
    end

    // R6: an under-threshold tick restarts the count
    scrub();
    fix_en = 1'b1; fix_time = 7'd3; supply_code = 10'd100; level_code = 10'd97;
    ticks(2); level_code = 10'd50; ticks(1); level_code = 10'd97; ticks(2);
    check("R6 restart", fault, 1'b0);
    ticks(1);
    check("R6 full run", fault, 1'b1);

    // R7: dropping the enable clears the count
    scrub();
    fix_en = 1'b1; ticks(2);
    @(negedge clk) fix_en = 1'b0;
    @(negedge clk) fix_en = 1'b1;
    ticks(2);
    check("R7 enable drop", fault, 1'b0);

    // R10: no tick, no progress
    scrub();
    fix_en = 1'b1; fix_time = 7'd0;
    repeat (50) @(negedge clk);
    check("R10 no tick", fault, 1'b0);

    // R8: sticky hold, then clear
    ticks(1);
    check("R8 set", fault, 1'b1);
    fix_en = 1'b0;
    repeat (20) @(negedge clk);
    check("R8 hold", fault, 1'b1);
    @(negedge clk) fault_clr = 1'b1;
    @(negedge clk) fault_clr = 1'b0;
    check("R8 clear", fault, 1'b0);

    // R9: trip and clear together
    fix_en = 1'b1;
    @(negedge clk) begin tick = 1'b1; fault_clr = 1'b1; end
    @(negedge clk) begin tick = 1'b0; fault_clr = 1'b0; end
    check("R9 trip beats clear", fault, 1'b1);

    // R11: long limit, saturation, retrip after clear
    scrub();
    prog_en = 1'b1; prog_lvl = 7'd64; prog_time = 8'd255; level_code = 10'd60;
    ticks(254);
    check("R11 before limit", fault, 1'b0);
    ticks(1);
    check("R11 at limit", fault, 1'b1);
    ticks(3);
    @(negedge clk) fault_clr = 1'b1;
    @(negedge clk) fault_clr = 1'b0;
    check("R11 cleared", fault, 1'b0);
    ticks(1);
    check("R11 retrip saturated", fault, 1'b1);

    // R1: reset drops the latched fault
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) check("R1 reset clears fault", fault, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule